// File: doc/BRIEF.md
# Debug Address Breakpoint Comparator

This block watches the address of each transfer on a processor's local bus and raises debug trigger flags. It holds two comparator sets that work independently of each other. Each set has a lower and an upper 32-bit bound and its own mode. The mode makes the set disabled, or makes it match one exact address, any address inside its window, or any address outside its window. When a transfer matches an enabled set, that set's hit flag rises in the following cycle. A combined trigger rises at the same time, and it is the OR of the two sets.

Software and debug hardware configure the block through a small indexed register port. The port has a 5-bit index, a write strobe and 32-bit write data, and its read data is combinational. The upper bounds can be written and read back. The lower bounds can only be written, and a read of them returns zero. An attribute register selects the address space used by debug memory commands. Its value drives an output pin, and it comes out of reset selecting supervisor data space.

Top module: `dbg_addr_bkpt`

## Requirements
- R1: After reset all bounds are zero, both sets are disabled (mode 00), `hit0`, `hit1` and `trig` are low, and `attr_space` is 4'h5.
- R2: Mode 01 (exact): a set hits when the transfer address equals its lower bound. Any other address gives no hit.
- R3: Mode 10 (inside): a set hits when lower <= address <= upper, with both bounds included.
- R4: Mode 11 (outside): a set hits exactly when the inside condition of R3 is false.
- R5: Mode 00 (disabled): a set never hits, whatever the address.
- R6: The two sets use separate bounds and modes. `trig` equals `hit0 | hit1` in every cycle.
- R7: A hit flag and `trig` are registered. They rise in the cycle after a transfer with `xfer_valid` high, and they stay low after any cycle in which `xfer_valid` was low.
- R8: The upper bounds sit at index 5'h0C (set 0) and 5'h1C (set 1). Both can be written, and a read returns the stored 32-bit value.
- R9: The lower bounds sit at index 5'h0D (set 0) and 5'h1D (set 1). They can be written, and a read returns zero.
- R10: The mode registers sit at index 5'h06 (set 0) and 5'h07 (set 1) and use bits [1:0]. A read returns the mode in bits [1:0] and zero in all other bits. At any unmapped index a read returns zero and a write changes nothing.
- R11: The attribute register sits at index 5'h0E and uses bits [3:0]. It can be read and written, its value drives `attr_space`, and it changes only when it is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| xfer_valid | input | 1 | A bus transfer is present this cycle |
| xfer_addr | input | 32 | Address of the current transfer |
| reg_wr_en | input | 1 | Register write strobe |
| reg_idx | input | 5 | Register index for both read and write |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Combinational read data at `reg_idx` |
| hit0 | output | 1 | Set 0 matched the previous transfer |
| hit1 | output | 1 | Set 1 matched the previous transfer |
| trig | output | 1 | Combined trigger, the OR of both sets |
| attr_space | output | 4 | Address-space attribute for debug memory commands |

## Verification
The assertions check each hit against the mode, bounds and address as they stood in the previous cycle. They therefore assume that a register write becomes visible only after the edge on which it happens, so a transfer is compared against the configuration that was in place before that edge. The stimulus writes the configuration in cycles of its own, before the transfers that use it. Where a register write and a transfer fall in the same cycle, the reference model in the bench applies the write after it evaluates the transfer. Address values are chosen to hit the window edges at exactly lower, upper, lower-1 and upper+1, and to cover the full 32-bit range, so that the inclusive comparisons can be told apart from exclusive ones.

// File: rtl/dbg_bkpt_pkg.sv
package dbg_bkpt_pkg;
  localparam int ADDR_W = 32;
  localparam int IDX_W  = 5;
  localparam int NSETS  = 2;
  localparam int ATTR_W = 4;
  localparam logic [ATTR_W-1:0] ATTR_RST = 4'h5;

  localparam logic [IDX_W-1:0] IDX_MODE0 = 5'h06;
  localparam logic [IDX_W-1:0] IDX_MODE1 = 5'h07;
  localparam logic [IDX_W-1:0] IDX_HI0   = 5'h0C;
  localparam logic [IDX_W-1:0] IDX_LO0   = 5'h0D;
  localparam logic [IDX_W-1:0] IDX_ATTR  = 5'h0E;
  localparam logic [IDX_W-1:0] IDX_HI1   = 5'h1C;
  localparam logic [IDX_W-1:0] IDX_LO1   = 5'h1D;

  typedef enum logic [1:0] {
    BK_OFF     = 2'b00,
    BK_EXACT   = 2'b01,
    BK_INSIDE  = 2'b10,
    BK_OUTSIDE = 2'b11
  } bkpt_mode_e;

  // Register index of each field, per comparator set
  function automatic logic [IDX_W-1:0] lo_index(int s);
    return (s == 0) ? IDX_LO0 : IDX_LO1;
  endfunction

  function automatic logic [IDX_W-1:0] hi_index(int s);
    return (s == 0) ? IDX_HI0 : IDX_HI1;
  endfunction

  function automatic logic [IDX_W-1:0] mode_index(int s);
    return (s == 0) ? IDX_MODE0 : IDX_MODE1;
  endfunction

  // Inclusive window test
  function automatic logic in_window(logic [ADDR_W-1:0] a,
                                     logic [ADDR_W-1:0] lo,
                                     logic [ADDR_W-1:0] hi);
    return (a >= lo) && (a <= hi);
  endfunction

  function automatic logic set_match(bkpt_mode_e m,
                                     logic [ADDR_W-1:0] a,
                                     logic [ADDR_W-1:0] lo,
                                     logic [ADDR_W-1:0] hi);
    logic r;
    case (m)
      BK_EXACT:   r = (a == lo);
      BK_INSIDE:  r = in_window(a, lo, hi);
      BK_OUTSIDE: r = !in_window(a, lo, hi);
      default:    r = 1'b0;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/dbg_bkpt_regfile.sv
module dbg_bkpt_regfile
  import dbg_bkpt_pkg::*;
(
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_en,
  input  logic [IDX_W-1:0]             idx,
  input  logic [ADDR_W-1:0]            wdata,
  output logic [ADDR_W-1:0]            rdata,
  output logic [NSETS-1:0][ADDR_W-1:0] lo_q,
  output logic [NSETS-1:0][ADDR_W-1:0] hi_q,
  output logic [NSETS-1:0][1:0]        mode_q,
  output logic [ATTR_W-1:0]            attr_q
);
  localparam int MODE_W = 2;

  for (genvar s = 0; s < NSETS; s++) begin : g_set
    wire wr_lo   = wr_en && (idx == lo_index(s));
    wire wr_hi   = wr_en && (idx == hi_index(s));
    wire wr_mode = wr_en && (idx == mode_index(s));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        lo_q[s]   <= '0;
        hi_q[s]   <= '0;
        mode_q[s] <= BK_OFF;
      end else begin
        if (wr_lo)   lo_q[s]   <= wdata;
        if (wr_hi)   hi_q[s]   <= wdata;
        if (wr_mode) mode_q[s] <= wdata[MODE_W-1:0];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                          attr_q <= ATTR_RST;
    else if (wr_en && idx == IDX_ATTR)   attr_q <= wdata[ATTR_W-1:0];
  end

  // Lower bounds are write-only: they fall to the default and read zero
  always_comb begin
    rdata = '0;
    case (idx)
      IDX_HI0:   rdata = hi_q[0];
      IDX_HI1:   rdata = hi_q[1];
      IDX_MODE0: rdata = ADDR_W'(mode_q[0]);
      IDX_MODE1: rdata = ADDR_W'(mode_q[1]);
      IDX_ATTR:  rdata = ADDR_W'(attr_q);
      default:   rdata = '0;
    endcase
  end
endmodule

// File: rtl/dbg_bkpt_cmp.sv
module dbg_bkpt_cmp
  import dbg_bkpt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              valid,
  input  logic [ADDR_W-1:0] addr,
  input  logic [ADDR_W-1:0] lo,
  input  logic [ADDR_W-1:0] hi,
  input  logic [1:0]        mode,
  output logic              match_now,
  output logic              hit_q
);
  assign match_now = set_match(bkpt_mode_e'(mode), addr, lo, hi);

  always_ff @(posedge clk) begin
    if (!rst_n) hit_q <= 1'b0;
    else        hit_q <= valid && match_now;
  end
endmodule

// File: rtl/dbg_addr_bkpt.sv
module dbg_addr_bkpt
  import dbg_bkpt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              xfer_valid,
  input  logic [31:0]       xfer_addr,
  input  logic              reg_wr_en,
  input  logic [4:0]        reg_idx,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              hit0,
  output logic              hit1,
  output logic              trig,
  output logic [3:0]        attr_space
);
  logic [NSETS-1:0][ADDR_W-1:0] cfg_lo;
  logic [NSETS-1:0][ADDR_W-1:0] cfg_hi;
  logic [NSETS-1:0][1:0]        cfg_mode;
  logic [NSETS-1:0]             set_match_now;
  logic [NSETS-1:0]             set_hit;
  logic                         trig_q;

  dbg_bkpt_regfile u_regs (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (reg_wr_en),
    .idx    (reg_idx),
    .wdata  (reg_wdata),
    .rdata  (reg_rdata),
    .lo_q   (cfg_lo),
    .hi_q   (cfg_hi),
    .mode_q (cfg_mode),
    .attr_q (attr_space)
  );

  for (genvar s = 0; s < NSETS; s++) begin : g_cmp
    dbg_bkpt_cmp u_cmp (
      .clk       (clk),
      .rst_n     (rst_n),
      .valid     (xfer_valid),
      .addr      (xfer_addr),
      .lo        (cfg_lo[s]),
      .hi        (cfg_hi[s]),
      .mode      (cfg_mode[s]),
      .match_now (set_match_now[s]),
      .hit_q     (set_hit[s])
    );
  end

  // Combined trigger kept in its own register, qualified by the strobe
  always_ff @(posedge clk) begin
    if (!rst_n) trig_q <= 1'b0;
    else        trig_q <= xfer_valid && (|set_match_now);
  end

  assign hit0 = set_hit[0];
  assign hit1 = set_hit[1];
  assign trig = trig_q;
endmodule

// File: rtl/dbg_addr_bkpt_chk.sv
module dbg_addr_bkpt_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        xfer_valid,
  input logic [31:0] xfer_addr,
  input logic        reg_wr_en,
  input logic [4:0]  reg_idx,
  input logic [31:0] reg_rdata,
  input logic        hit0,
  input logic        hit1,
  input logic        trig,
  input logic [3:0]  attr_space,
  input logic [1:0]  mode0,
  input logic [31:0] lo0,
  input logic [31:0] hi0
);
  assert_trig_or_R6: assert property (@(posedge clk) disable iff (!rst_n)
    trig == (hit0 || hit1));

  assert_needs_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (hit0 || hit1 || trig) |-> $past(xfer_valid));

  assert_off_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    hit0 |-> ($past(mode0) != 2'b00));

  assert_exact_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (hit0 && $past(mode0) == 2'b01) |-> ($past(xfer_addr) == $past(lo0)));

  assert_inside_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (hit0 && $past(mode0) == 2'b10) |->
      ($past(xfer_addr) >= $past(lo0) && $past(xfer_addr) <= $past(hi0)));

  assert_outside_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (hit0 && $past(mode0) == 2'b11) |->
      ($past(xfer_addr) < $past(lo0) || $past(xfer_addr) > $past(hi0)));

  assert_lo_reads_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_idx == 5'h0D || reg_idx == 5'h1D) |-> (reg_rdata == 32'h0));

  assert_attr_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(reg_wr_en && reg_idx == 5'h0E) |-> $stable(attr_space));
endmodule

bind dbg_addr_bkpt dbg_addr_bkpt_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .xfer_valid (xfer_valid),
  .xfer_addr  (xfer_addr),
  .reg_wr_en  (reg_wr_en),
  .reg_idx    (reg_idx),
  .reg_rdata  (reg_rdata),
  .hit0       (hit0),
  .hit1       (hit1),
  .trig       (trig),
  .attr_space (attr_space),
  .mode0      (cfg_mode[0]),
  .lo0        (cfg_lo[0]),
  .hi0        (cfg_hi[0])
);

// File: tb/dbg_addr_bkpt_bench.sv
`timescale 1ns/1ps
module dbg_addr_bkpt_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        xfer_valid = 1'b0;
  logic [31:0] xfer_addr = '0;
  logic        reg_wr_en = 1'b0;
  logic [4:0]  reg_idx = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        hit0, hit1, trig;
  logic [3:0]  attr_space;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  dbg_addr_bkpt u_dbg_addr_bkpt (
    .clk(clk), .rst_n(rst_n), .xfer_valid(xfer_valid), .xfer_addr(xfer_addr),
    .reg_wr_en(reg_wr_en), .reg_idx(reg_idx), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .hit0(hit0), .hit1(hit1), .trig(trig),
    .attr_space(attr_space)
  );

  // Behavioural reference state
  longint unsigned m_lo[2];
  longint unsigned m_hi[2];
  int              m_mode[2];
  int              m_attr;

  function automatic int m_read(int idx);
    if (idx == 'h0C) return int'(m_hi[0]);
    if (idx == 'h1C) return int'(m_hi[1]);
    if (idx == 'h06) return m_mode[0];
    if (idx == 'h07) return m_mode[1];
    if (idx == 'h0E) return m_attr;
    return 0;
  endfunction

  function automatic bit m_hit(int s, longint unsigned a);
    bit inside_w;
    inside_w = !(a < m_lo[s]) && !(a > m_hi[s]);
    if (m_mode[s] == 1) return a == m_lo[s];
    if (m_mode[s] == 2) return inside_w;
    if (m_mode[s] == 3) return !inside_w;
    return 0;
  endfunction

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // One clock: drive, check read data, clock, update model, check hits
  task automatic step(string tag, bit v, logic [31:0] a,
                      bit we, logic [4:0] idx, logic [31:0] wd);
    bit e0, e1;
    xfer_valid = v; xfer_addr = a; reg_wr_en = we; reg_idx = idx; reg_wdata = wd;
    #1;
    chk(tag, "reg_rdata", reg_rdata, 32'(m_read(int'(idx))));
    e0 = v && m_hit(0, longint'(a));
    e1 = v && m_hit(1, longint'(a));
    @(posedge clk);
    if (we) begin
      if (idx == 5'h0D) m_lo[0] = longint'(wd);
      if (idx == 5'h1D) m_lo[1] = longint'(wd);
      if (idx == 5'h0C) m_hi[0] = longint'(wd);
      if (idx == 5'h1C) m_hi[1] = longint'(wd);
      if (idx == 5'h06) m_mode[0] = int'(wd[1:0]);
      if (idx == 5'h07) m_mode[1] = int'(wd[1:0]);
      if (idx == 5'h0E) m_attr = int'(wd[3:0]);
    end
    @(negedge clk);
    chk(tag, "hit0", 32'(hit0), 32'(e0));
    chk(tag, "hit1", 32'(hit1), 32'(e1));
    chk(tag, "trig", 32'(trig), 32'(e0 | e1));
    chk(tag, "attr_space", 32'(attr_space), 32'(m_attr));
  endtask

  task automatic wr(string tag, logic [4:0] idx, logic [31:0] d);
    step(tag, 0, 32'h0, 1, idx, d);
  endtask

  task automatic xf(string tag, logic [31:0] a);
    step(tag, 1, a, 0, 5'h00, 32'h0);
  endtask

  task automatic rd(string tag, logic [4:0] idx);
    step(tag, 0, 32'h0, 0, idx, 32'h0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int s = 0; s < 2; s++) begin m_lo[s] = 0; m_hi[s] = 0; m_mode[s] = 0; end
    m_attr = 5;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state
    chk("R1", "hit0", 32'(hit0), 0);
    chk("R1", "trig", 32'(trig), 0);
    chk("R1", "attr_space", 32'(attr_space), 32'h5);
    foreach (m_lo[s]) begin
      rd("R1", s == 0 ? 5'h0C : 5'h1C);
      rd("R1", s == 0 ? 5'h06 : 5'h07);
    end
    rd("R1", 5'h0E);
    // R5: disabled sets with zero bounds never hit
    xf("R5", 32'h0);
    xf("R5", 32'hFFFF_FFFF);
    // R8 / R9: bound register access
    wr("R8", 5'h0C, 32'h1000_00FF);
    rd("R8", 5'h0C);
    wr("R9", 5'h0D, 32'h1000_0000);
    rd("R9", 5'h0D);
    xf("R5", 32'h1000_0000);
    // R2: exact
    wr("R10", 5'h06, 32'h1);
    rd("R10", 5'h06);
    xf("R2", 32'h1000_0000);
    xf("R2", 32'h1000_0001);
    xf("R2", 32'h0FFF_FFFF);
    // R7: strobe low never fires
    step("R7", 0, 32'h1000_0000, 0, 5'h00, 0);
    xf("R7", 32'h1000_0000);
    xf("R7", 32'h1000_0000);
    // R3: inside, inclusive edges
    wr("R3", 5'h06, 32'hFFFF_FFFE);
    rd("R10", 5'h06);
    foreach (m_lo[s]) begin
      xf("R3", 32'h1000_0000 - 32'(s));
      xf("R3", 32'h1000_00FF + 32'(s));
    end
    xf("R3", 32'h1000_0080);
    // R4: outside
    wr("R4", 5'h06, 32'h3);
    foreach (m_lo[s]) begin
      xf("R4", 32'h1000_0000 - 32'(s));
      xf("R4", 32'h1000_00FF + 32'(s));
    end
    xf("R4", 32'h0);
    xf("R4", 32'hFFFF_FFFF);
    // R6: independent sets
    wr("R6", 5'h1D, 32'h0000_2000);
    wr("R6", 5'h1C, 32'h0000_3000);
    rd("R9", 5'h1D);
    rd("R8", 5'h1C);
    wr("R6", 5'h07, 32'h2);
    wr("R6", 5'h06, 32'h1);
    xf("R6", 32'h0000_2500);
    xf("R6", 32'h1000_0000);
    xf("R6", 32'h0000_3001);
    wr("R6", 5'h06, 32'h3);
    xf("R6", 32'h0000_3000);
    // write with transfer in the same cycle: old config applies
    step("R6", 1, 32'h0000_2000, 1, 5'h07, 32'h0);
    xf("R5", 32'h0000_2000);
    // R4: full-range window makes outside never match
    wr("R4", 5'h0D, 32'h0);
    wr("R4", 5'h0C, 32'hFFFF_FFFF);
    xf("R4", 32'h0);
    xf("R4", 32'hFFFF_FFFF);
    // R10: unmapped index ignored
    wr("R10", 5'h03, 32'hFFFF_FFFF);
    rd("R10", 5'h03);
    rd("R10", 5'h1F);
    rd("R10", 5'h0C);
    rd("R10", 5'h06);
    // R11: attribute register
    wr("R11", 5'h0E, 32'hFFFF_FFF3);
    rd("R11", 5'h0E);
    wr("R11", 5'h0C, 32'h1234_5678);
    rd("R11", 5'h0E);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule